// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two unsigned W-bit numbers by taking one bit pair per clock. Each operand sits in a shift register. A single carry flip-flop links the bit positions. On every shift step, the low bits of both registers and the stored carry feed a full adder. The sum bit enters the top of the augend register as that register moves right. After W steps the augend register holds the sum.

The addend register feeds its own low bit back into its top, so after W steps it holds its original value again. A second start therefore adds the same addend once more.

The user first loads both operands in parallel while the block is idle. The user then pulses start. The block shifts for exactly W cycles on its own, stops, and raises done. The sum and the final carry can then be read from the outputs. A load or a start that arrives while the block is busy has no effect.

Top module: `serial_adder`

## Requirements
- R1: After synchronous reset, sum, cout, busy and done are all 0.
- R2: When idle, a load cycle sets sum to augend_in, captures addend_in, clears cout and clears done, all visible after the next clock edge.
- R3: After the start pulse is sampled, busy is 1 for exactly W clock edges. At the end, sum equals (augend + addend) mod 2^W.
- R4: After done, cout equals bit W of augend + addend. The carry flip-flop sets when both serial bits are 1, clears when both are 0, and otherwise holds. Start clears it.
- R5: done rises on the same edge that busy falls, W edges after start is sampled. done is never 1 while busy is 1.
- R6: The addend survives an operation. A second start with no new load gives sum = (previous sum + addend) mod 2^W.
- R7: A load asserted while busy is ignored. The result and the timing match a run with no such load.
- R8: A start asserted while busy is ignored. The operation still ends W edges after the first start.
- R9: While idle with load and start low, sum, cout and done hold their values.
- R10: When load and start are both high in the same idle cycle, only the load takes effect and no operation begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Parallel load of both operands when idle |
| augend_in | input | W | First operand |
| addend_in | input | W | Second operand |
| start | input | 1 | Begins a W-step addition when idle |
| busy | output | 1 | High while shifting |
| done | output | 1 | High once an addition has finished, until the next load or start |
| sum | output | W | Parallel contents of the augend/result register |
| cout | output | 1 | Carry flip-flop value |

## Verification
The bench builds the adder with the default width W = 8. At this width, the all-ones-plus-one wrap, carries that run through every bit position, and alternating bit patterns with no carry can all be reached with hand-picked operands. With eight steps, the exact done latency can also be counted cycle by cycle. Disturbances injected in the middle of a run, either a stray load or a stray start, fall well inside the busy window.

// File: rtl/serial_adder.sv
module serial_adder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] augend_in,
  input  logic [W-1:0] addend_in,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  a_q, b_q;
  logic          c_q, busy_q, done_q;
  logic [CW-1:0] cnt;

  wire x    = a_q[0];
  wire y    = b_q[0];
  wire s    = x ^ y ^ c_q;
  wire last = (cnt == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
    end else if (!busy_q) begin
      if (load) begin
        a_q    <= augend_in;
        b_q    <= addend_in;
        c_q    <= 1'b0;
        done_q <= 1'b0;
        cnt    <= '0;
      end else if (start) begin
        c_q    <= 1'b0;
        done_q <= 1'b0;
        cnt    <= '0;
        busy_q <= 1'b1;
      end
    end else begin
      a_q <= {s, a_q[W-1:1]};
      b_q <= {y, b_q[W-1:1]};
      case ({x & y, ~x & ~y})
        2'b10:   c_q <= 1'b1;
        2'b01:   c_q <= 1'b0;
        default: c_q <= c_q;
      endcase
      cnt <= cnt + 1'b1;
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign sum  = a_q;
  assign cout = c_q;
endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         cout,
  input logic [W-1:0] augend_in,
  input logic [W-1:0] sum
);
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !busy) |=> (sum == $past(augend_in) && !cout && !done && !busy));

  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(busy) && !busy));

  // R5
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load && !start) |=> ($stable(sum) && $stable(cout) && $stable(done)));

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && load && start) |=> !busy);
endmodule

bind serial_adder serial_adder_chk #(.W(W)) u_chk (.*);

// File: tb/sim_serial_adder.sv
module sim_serial_adder;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] augend_in = '0;
  logic [W-1:0] addend_in = '0;
  logic         busy, done, cout;
  logic [W-1:0] sum;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_adder #(.W(W)) u0 (
    .clk(clk), .rst(rst), .load(load), .augend_in(augend_in),
    .addend_in(addend_in), .start(start), .busy(busy), .done(done),
    .sum(sum), .cout(cout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    load = 1'b1; augend_in = a; addend_in = b;
    @(negedge clk);
    load = 1'b0;
    check(sum == a, "R2 sum", sum, a);
    check(!done && !cout && !busy, "R2 flags", {done, cout, busy}, 0);
  endtask

  // kind: 0 plain, 1 stray load mid-run, 2 stray start mid-run
  task automatic run(input int kind, output int lat);
    lat = -1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= W + 3; i++) begin
      if (i == 3 && kind == 1) begin
        load = 1'b1; augend_in = 8'h63; addend_in = 8'h63;
      end
      if (i == 3 && kind == 2) start = 1'b1;
      @(negedge clk);
      load = 1'b0;
      start = 1'b0;
      if (done) begin
        lat = i;
        break;
      end
      check(busy, "R3 busy", busy, 1);
    end
  endtask

  task automatic t_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] full;
    int lat;
    full = {1'b0, a} + {1'b0, b};
    do_load(a, b);
    run(0, lat);
    check(lat == W, "R5 latency", lat, W);
    check(!busy, "R5 busy low", busy, 0);
    check(sum == full[W-1:0], "R3 sum", sum, full[W-1:0]);
    check(cout == full[W], "R4 cout", cout, full[W]);
  endtask

  task automatic t_accumulate();
    int lat;
    do_load(8'd100, 8'd30);
    run(0, lat);
    check(sum == 8'd130, "R3 first", sum, 130);
    run(0, lat);
    check(sum == 8'd160, "R6 reuse addend", sum, 160);
    run(0, lat);
    check(sum == 8'd190, "R6 third", sum, 190);
    check(cout == 1'b0, "R4 no carry", cout, 0);
  endtask

  task automatic t_busy_load();
    int lat;
    do_load(8'd10, 8'd20);
    run(1, lat);
    check(lat == W, "R7 latency", lat, W);
    check(sum == 8'd30, "R7 sum", sum, 30);
  endtask

  task automatic t_busy_start();
    int lat;
    do_load(8'd200, 8'd90);
    run(2, lat);
    check(lat == W, "R8 latency", lat, W);
    check(sum == 8'd34, "R8 sum", sum, 34);
    check(cout == 1'b1, "R8 cout", cout, 1);
  endtask

  task automatic t_idle_hold();
    logic [W-1:0] s0;
    logic c0, d0;
    s0 = sum; c0 = cout; d0 = done;
    repeat (6) @(negedge clk);
    check(sum == s0, "R9 sum hold", sum, s0);
    check(cout == c0 && done == d0, "R9 flags hold", {cout, done}, {c0, d0});
  endtask

  task automatic t_priority();
    @(negedge clk);
    load = 1'b1; start = 1'b1; augend_in = 8'd7; addend_in = 8'd9;
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    check(sum == 8'd7 && !busy, "R10 load only", sum, 7);
    repeat (W + 2) @(negedge clk);
    check(!done && !busy, "R10 no run", {done, busy}, 0);
    check(sum == 8'd7, "R10 sum kept", sum, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(sum == '0, "R1 sum", sum, 0);
    check(!busy && !done && !cout, "R1 flags", {busy, done, cout}, 0);
    t_add(8'd5, 8'd3);
    t_add(8'd200, 8'd100);
    t_add(8'd255, 8'd1);
    t_add(8'd0, 8'd0);
    t_add(8'd170, 8'd85);
    t_add(8'd255, 8'd255);
    t_idle_hold();
    t_accumulate();
    t_busy_load();
    t_busy_start();
    t_priority();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule